// File: doc/BRIEF.md
# ATAPI task-file transfer controller

This block is the device side of an ATAPI-style packet interface. A host sees a small byte-wide register file (error/feature, count, sector, byte-count low and high, device, status/command, alternate status/control) and a 16-bit data port. A PACKET command opens a command phase. In that phase the host writes six words, and those twelve bytes go to a packet decoder over a valid/ready handshake. The decoder can load the sector buffer and then open a data phase. The phase moves the buffer to or from the host by PIO through the data port, or by DMA through a pair of valid/ready word streams. The block keeps the status, interrupt-reason (count) and byte-count registers at fixed per-phase values, and it drives a maskable interrupt request.

The decoder runs a multi-sector read by giving a sectors-left count when it starts each sector. When a read phase ends with sectors still remaining, the block pulses `next_sector_req` and decrements the count. The decoder then refills the buffer and starts the next phase. Back-pressure rules: `pkt_data` holds steady while `pkt_valid` is high and `pkt_ready` is low. A DMA read word moves on a cycle with `dma_rd_valid && dma_rd_ready`. A DMA write word moves on a cycle with `dma_wr_valid && dma_wr_ready`. A fill word moves on a cycle with `fill_valid && fill_ready`. `fill_ready` is high only while the block is idle or busy, no packet is waiting, and the buffer has room.

The register addresses are 0 error(read)/feature(write), 1 count, 2 sector, 3 byte-count low, 4 byte-count high, 5 device, 6 status(read)/command(write) and 7 alternate status(read)/control(write). The commands are 0x00 abort, 0x08 device reset and 0xA0 packet.

Top module: `atapi_xfer_ctrl`

## Requirements
- R1: After reset, and after command 0x08, the registers read as follows: error 0x01, count 0x01, sector 0x81, byte-count low 0x14, byte-count high 0xEB and status 0x00. `intrq` is low, and the next packet is delivered with `pkt_after_reset` = 1.
- R2: Command 0xA0 sets status to 0x58, error to feature[1:0] and count to 0x01 (bit 0 = command, bit 1 = to-host).
- R3: After six data-port writes, status becomes 0xD0 and `pkt_valid` rises. `pkt_data[16i+15:16i]` holds the i-th word written. `pkt_data` holds stable until `pkt_ready`. `pkt_after_reset` is 1 only for the first packet after a reset.
- R4: `ph_start` with feature bit 0 clear opens a PIO phase. It sets status to 0x58, error to 0x00, byte-count {high,low} to `ph_len`, and count to 0x02 (read) or 0x00 (write), and it raises the interrupt.
- R5: `ph_start` with feature bit 0 set opens a DMA phase. It sets status to 0xD0, leaves both byte-count registers unchanged, and raises no interrupt.
- R6: In a PIO read, `data_rdata` shows the buffer words in fill order, and each `data_rd` advances one word. After `ph_len` bytes, status becomes 0x50 and count 0x03, the interrupt is raised, and `next_sector_req` pulses if sectors remain.
- R7: In a PIO write, each `data_wr` stores one word, in order, readable through `buf_raddr`/`buf_rdata`. After `ph_len` bytes, status becomes 0x50 and count 0x03, and the interrupt is raised.
- R8: When a DMA phase ends with no sectors left, status becomes 0x50 and count 0x03, the interrupt is raised and `dma_done` pulses. When a DMA read ends with sectors left, `next_sector_req` pulses and status stays 0xD0.
- R9: A read of address 6 clears the pending interrupt when status bit 7 (BSY) is clear, and leaves it pending when BSY is set. A read of address 7 never clears it.
- R10: Control bit 1 forces `intrq` low without discarding the pending interrupt.
- R11: Command 0x00 aborts any phase. It sets status 0x51 and error 0x04, returns to idle and raises the interrupt.
- R12: A data-port read outside a PIO read phase returns 0xFFFF and changes no register.
- R13: Any command write first clears the pending interrupt. An unknown command otherwise changes nothing.
- R14: `cmd_done` from the decoder sets status 0x50, error 0x00 and count 0x03, and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| data_wr | input | 1 | Data port write strobe |
| data_wdata | input | 16 | Data port write word |
| data_rd | input | 1 | Data port read strobe |
| data_rdata | output | 16 | Data port read word |
| intrq | output | 1 | Masked interrupt request |
| pkt_valid | output | 1 | Command packet valid |
| pkt_ready | input | 1 | Decoder accepts packet |
| pkt_data | output | 96 | Twelve packet bytes |
| pkt_after_reset | output | 1 | First packet since reset |
| ph_start | input | 1 | Decoder opens a data phase |
| ph_dir_in | input | 1 | Phase direction, 1 = to host |
| ph_len | input | LEN_W | Phase length in bytes |
| ph_sectors | input | SEC_W | Sectors left after this one |
| cmd_done | input | 1 | Decoder completes with no data |
| next_sector_req | output | 1 | Pulse: refill for next sector |
| fill_valid | input | 1 | Buffer fill word valid |
| fill_ready | output | 1 | Buffer accepts fill word |
| fill_data | input | 16 | Buffer fill word |
| buf_raddr | input | $clog2(BUF_WORDS) | Decoder buffer read address |
| buf_rdata | output | 16 | Decoder buffer read word |
| dma_rd_valid | output | 1 | DMA read word valid |
| dma_rd_ready | input | 1 | DMA read word taken |
| dma_rd_data | output | 16 | DMA read word |
| dma_wr_valid | input | 1 | DMA write word valid |
| dma_wr_ready | output | 1 | Block accepts DMA write word |
| dma_wr_data | input | 16 | DMA write word |
| dma_done | output | 1 | Pulse: DMA phase complete |

## Verification
A wrong phase state or word offset shows up at the next data access. The host reads the wrong buffer word, reads 0xFFFF too early, or sees the status and count registers settle on the final values one word early or late. Either symptom is visible in the cycle after the faulty strobe. A pending interrupt flag that was lost or left set shows up on `intrq` in the cycle after the status read, the mask write or the command write that should have changed it. A stale packet register or a stale was-reset flag shows up when the decoder takes the next packet.

// File: rtl/atapi_pkg.sv
package atapi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_BUSY, ST_PIO_IN, ST_PIO_OUT, ST_DMA_IN, ST_DMA_OUT
  } xfer_state_e;

  localparam logic [2:0] A_ERRFEAT = 3'd0;
  localparam logic [2:0] A_COUNT   = 3'd1;
  localparam logic [2:0] A_SECTOR  = 3'd2;
  localparam logic [2:0] A_BC_LO   = 3'd3;
  localparam logic [2:0] A_BC_HI   = 3'd4;
  localparam logic [2:0] A_DEVICE  = 3'd5;
  localparam logic [2:0] A_STATCMD = 3'd6;
  localparam logic [2:0] A_ALTCTL  = 3'd7;

  localparam logic [7:0] CMD_ABORT  = 8'h00;
  localparam logic [7:0] CMD_DEVRST = 8'h08;
  localparam logic [7:0] CMD_PACKET = 8'hA0;

  localparam logic [7:0] STS_XFER  = 8'h58;
  localparam logic [7:0] STS_BUSY  = 8'hD0;
  localparam logic [7:0] STS_READY = 8'h50;
  localparam logic [7:0] STS_FAULT = 8'h51;
  localparam int BSY_BIT = 7;
  localparam int DRQ_BIT = 3;
  localparam int NIEN_BIT = 1;

  localparam logic [7:0] CNT_CMD  = 8'h01;
  localparam logic [7:0] CNT_IN   = 8'h02;
  localparam logic [7:0] CNT_OUT  = 8'h00;
  localparam logic [7:0] CNT_DONE = 8'h03;

  localparam int PKT_WORDS = 6;
endpackage

// File: rtl/atapi_sector_buf.sv
module atapi_sector_buf #(
  parameter int WORDS = 32,
  parameter int W     = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/atapi_irq_ctrl.sv
module atapi_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  input  logic mask,
  output logic pending,
  output logic intrq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pending <= 1'b0;
    else if (raise) pending <= 1'b1;
    else if (clear) pending <= 1'b0;
  end

  assign intrq = pending & ~mask;
endmodule

// File: rtl/atapi_xfer_ctrl.sv
module atapi_xfer_ctrl
  import atapi_pkg::*;
#(
  parameter int BUF_WORDS = 32,
  parameter int LEN_W     = 16,
  parameter int SEC_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [2:0]                   reg_addr,
  input  logic [7:0]                   reg_wdata,
  output logic [7:0]                   reg_rdata,
  input  logic                         data_wr,
  input  logic [15:0]                  data_wdata,
  input  logic                         data_rd,
  output logic [15:0]                  data_rdata,
  output logic                         intrq,
  output logic                         pkt_valid,
  input  logic                         pkt_ready,
  output logic [95:0]                  pkt_data,
  output logic                         pkt_after_reset,
  input  logic                         ph_start,
  input  logic                         ph_dir_in,
  input  logic [LEN_W-1:0]             ph_len,
  input  logic [SEC_W-1:0]             ph_sectors,
  input  logic                         cmd_done,
  output logic                         next_sector_req,
  input  logic                         fill_valid,
  output logic                         fill_ready,
  input  logic [15:0]                  fill_data,
  input  logic [$clog2(BUF_WORDS)-1:0] buf_raddr,
  output logic [15:0]                  buf_rdata,
  output logic                         dma_rd_valid,
  input  logic                         dma_rd_ready,
  output logic [15:0]                  dma_rd_data,
  input  logic                         dma_wr_valid,
  output logic                         dma_wr_ready,
  input  logic [15:0]                  dma_wr_data,
  output logic                         dma_done
);
  localparam int PTR_W = $clog2(BUF_WORDS);
  localparam int OFF_W = PTR_W + 1;
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(BUF_WORDS);
  localparam logic [OFF_W-1:0] OFF_PKT = OFF_W'(PKT_WORDS);

  xfer_state_e       st_q, st_n;
  logic [7:0]        status_q, status_n, error_q, error_n, count_q, count_n;
  logic [7:0]        sector_q, sector_n, bclo_q, bclo_n, bchi_q, bchi_n;
  logic [7:0]        feat_q, feat_n, dev_q, dev_n, ctrl_q, ctrl_n;
  logic [OFF_W-1:0]  woff_q, woff_n, wlen_q, wlen_n, fptr_q, fptr_n;
  logic [SEC_W-1:0]  secs_q, secs_n;
  logic              pktv_q, pktv_n, wasrst_q, wasrst_n;
  logic              raise, clr, nsr_n, ddone_n;
  logic              irq_pending;
  logic [15:0]       pkt_w [PKT_WORDS];

  logic              cmd_wr, last_word, ctl_free, fill_fire;
  logic [LEN_W:0]    half_len;
  logic [OFF_W-1:0]  ph_wlen;
  logic              buf_we;
  logic [PTR_W-1:0]  buf_waddr;
  logic [15:0]       buf_wdata, rd_a;

  assign cmd_wr    = reg_wr && (reg_addr == A_STATCMD);
  assign last_word = (woff_q + 1'b1) == wlen_q;
  assign ctl_free  = ((st_q == ST_IDLE) || (st_q == ST_BUSY)) && !pktv_q;
  assign fill_ready = ctl_free && (fptr_q < OFF_MAX);
  assign fill_fire  = fill_valid && fill_ready;

  // Byte length rounded up to words, clamped to 1..BUF_WORDS.
  always_comb begin
    half_len = ({1'b0, ph_len} + 1'b1) >> 1;
    if (half_len == '0)                        ph_wlen = OFF_W'(1);
    else if (half_len > (LEN_W+1)'(BUF_WORDS)) ph_wlen = OFF_MAX;
    else                                       ph_wlen = half_len[OFF_W-1:0];
  end

  always_comb begin
    st_n = st_q; status_n = status_q; error_n = error_q; count_n = count_q;
    sector_n = sector_q; bclo_n = bclo_q; bchi_n = bchi_q; feat_n = feat_q;
    dev_n = dev_q; ctrl_n = ctrl_q; woff_n = woff_q; wlen_n = wlen_q;
    fptr_n = fptr_q; secs_n = secs_q; pktv_n = pktv_q; wasrst_n = wasrst_q;
    raise = 1'b0; nsr_n = 1'b0; ddone_n = 1'b0;
    clr = reg_rd && (reg_addr == A_STATCMD) && !status_q[BSY_BIT];
    if (fill_fire) fptr_n = fptr_q + 1'b1;

    if (reg_wr) begin
      unique case (reg_addr)
        A_ERRFEAT: feat_n   = reg_wdata;
        A_COUNT:   count_n  = reg_wdata;
        A_SECTOR:  sector_n = reg_wdata;
        A_BC_LO:   bclo_n   = reg_wdata;
        A_BC_HI:   bchi_n   = reg_wdata;
        A_DEVICE:  dev_n    = reg_wdata;
        A_ALTCTL:  ctrl_n   = reg_wdata;
        default:   ;
      endcase
    end

    if (cmd_wr) begin
      clr = 1'b1;
      unique case (reg_wdata)
        CMD_ABORT: begin
          st_n = ST_IDLE; status_n = STS_FAULT; error_n = 8'h04;
          pktv_n = 1'b0; fptr_n = '0; raise = 1'b1;
        end
        CMD_DEVRST: begin
          st_n = ST_IDLE; status_n = 8'h00; error_n = 8'h01; count_n = 8'h01;
          sector_n = 8'h81; bclo_n = 8'h14; bchi_n = 8'hEB; dev_n = 8'h00;
          feat_n = 8'h00; pktv_n = 1'b0; wasrst_n = 1'b1; fptr_n = '0;
          secs_n = '0;
        end
        CMD_PACKET: begin
          st_n = ST_CMD; status_n = STS_XFER; error_n = {6'b0, feat_q[1:0]};
          count_n = CNT_CMD; woff_n = '0; wlen_n = OFF_PKT;
        end
        default: ;
      endcase
    end else begin
      unique case (st_q)
        ST_CMD: if (data_wr) begin
          woff_n = woff_q + 1'b1;
          if (last_word) begin
            st_n = ST_BUSY;
            status_n = (status_q & ~(8'h1 << DRQ_BIT)) | (8'h1 << BSY_BIT);
            pktv_n = 1'b1; fptr_n = '0;
          end
        end
        ST_IDLE, ST_BUSY: begin
          if (pktv_q && pkt_ready) begin
            pktv_n = 1'b0; wasrst_n = 1'b0;
          end else if (!pktv_q && ph_start) begin
            error_n = 8'h00; secs_n = ph_sectors; woff_n = '0;
            wlen_n = ph_wlen; fptr_n = '0;
            count_n = ph_dir_in ? CNT_IN : CNT_OUT;
            if (feat_q[0]) begin
              st_n = ph_dir_in ? ST_DMA_IN : ST_DMA_OUT;
              status_n = STS_BUSY;
            end else begin
              st_n = ph_dir_in ? ST_PIO_IN : ST_PIO_OUT;
              status_n = STS_XFER;
              bclo_n = ph_len[7:0];
              bchi_n = 8'(ph_len >> 8);
              raise = 1'b1;
            end
          end else if (!pktv_q && cmd_done) begin
            st_n = ST_IDLE; status_n = STS_READY; error_n = 8'h00;
            count_n = CNT_DONE; raise = 1'b1;
          end
        end
        ST_PIO_IN, ST_PIO_OUT: begin
          if ((st_q == ST_PIO_IN && data_rd) || (st_q == ST_PIO_OUT && data_wr)) begin
            woff_n = woff_q + 1'b1;
            if (last_word) begin
              st_n = ST_IDLE;
              status_n = status_q & ~(8'h1 << DRQ_BIT);
              count_n = CNT_DONE; raise = 1'b1;
              if (st_q == ST_PIO_IN && secs_q != '0) begin
                nsr_n = 1'b1; secs_n = secs_q - 1'b1;
              end
            end
          end
        end
        ST_DMA_IN, ST_DMA_OUT: begin
          if ((st_q == ST_DMA_IN && dma_rd_ready) || (st_q == ST_DMA_OUT && dma_wr_valid)) begin
            woff_n = woff_q + 1'b1;
            if (last_word) begin
              if (st_q == ST_DMA_IN && secs_q != '0) begin
                st_n = ST_BUSY; nsr_n = 1'b1; secs_n = secs_q - 1'b1;
              end else begin
                st_n = ST_IDLE; status_n = STS_READY; count_n = CNT_DONE;
                raise = 1'b1; ddone_n = 1'b1;
              end
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; status_q <= 8'h00; error_q <= 8'h01; count_q <= 8'h01;
      sector_q <= 8'h81; bclo_q <= 8'h14; bchi_q <= 8'hEB; feat_q <= 8'h00;
      dev_q <= 8'h00; ctrl_q <= 8'h00; woff_q <= '0; wlen_q <= '0;
      fptr_q <= '0; secs_q <= '0; pktv_q <= 1'b0; wasrst_q <= 1'b1;
      next_sector_req <= 1'b0; dma_done <= 1'b0;
    end else begin
      st_q <= st_n; status_q <= status_n; error_q <= error_n; count_q <= count_n;
      sector_q <= sector_n; bclo_q <= bclo_n; bchi_q <= bchi_n; feat_q <= feat_n;
      dev_q <= dev_n; ctrl_q <= ctrl_n; woff_q <= woff_n; wlen_q <= wlen_n;
      fptr_q <= fptr_n; secs_q <= secs_n; pktv_q <= pktv_n; wasrst_q <= wasrst_n;
      next_sector_req <= nsr_n; dma_done <= ddone_n;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_CMD && data_wr && !cmd_wr) pkt_w[woff_q[2:0]] <= data_wdata;
  end

  for (genvar i = 0; i < PKT_WORDS; i++) begin : g_pkt
    assign pkt_data[16*i +: 16] = pkt_w[i];
  end

  assign buf_we    = fill_fire || (!cmd_wr && ((st_q == ST_PIO_OUT && data_wr) ||
                                                (st_q == ST_DMA_OUT && dma_wr_valid)));
  assign buf_waddr = fill_fire ? fptr_q[PTR_W-1:0] : woff_q[PTR_W-1:0];
  assign buf_wdata = fill_fire ? fill_data : (st_q == ST_DMA_OUT ? dma_wr_data : data_wdata);

  atapi_sector_buf #(.WORDS(BUF_WORDS), .W(16)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr_a(woff_q[PTR_W-1:0]), .rdata_a(rd_a),
    .raddr_b(buf_raddr), .rdata_b(buf_rdata)
  );

  atapi_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .raise(raise), .clear(clr),
    .mask(ctrl_q[NIEN_BIT]), .pending(irq_pending), .intrq(intrq)
  );

  always_comb begin
    unique case (reg_addr)
      A_ERRFEAT: reg_rdata = error_q;
      A_COUNT:   reg_rdata = count_q;
      A_SECTOR:  reg_rdata = sector_q;
      A_BC_LO:   reg_rdata = bclo_q;
      A_BC_HI:   reg_rdata = bchi_q;
      A_DEVICE:  reg_rdata = dev_q;
      default:   reg_rdata = status_q;
    endcase
  end

  assign data_rdata      = (st_q == ST_PIO_IN) ? rd_a : 16'hFFFF;
  assign dma_rd_valid    = (st_q == ST_DMA_IN);
  assign dma_rd_data     = rd_a;
  assign dma_wr_ready    = (st_q == ST_DMA_OUT);
  assign pkt_valid       = pktv_q;
  assign pkt_after_reset = wasrst_q;
endmodule

// File: rtl/atapi_xfer_chk.sv
module atapi_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [2:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  status_q,
  input logic [7:0]  error_q,
  input logic [7:0]  count_q,
  input logic        irq_pending,
  input logic        raise,
  input logic        pkt_valid,
  input logic        pkt_ready,
  input logic [95:0] pkt_data,
  input logic        dma_done,
  input logic        next_sector_req
);
  assert_pkt_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd6 && reg_wdata == 8'hA0) |=> (status_q == 8'h58 && count_q == 8'h01));

  assert_pkt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd6 && reg_wdata == 8'h00) |=> (status_q == 8'h51 && error_q == 8'h04 && irq_pending));

  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd6 && !status_q[7] && !raise) |=> !irq_pending);

  assert_busy_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd6 && status_q[7] && irq_pending && !reg_wr) |=> irq_pending);

  assert_dma_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> (status_q == 8'h50 && count_q == 8'h03 && irq_pending));

  assert_next_sector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    next_sector_req |-> !status_q[3]);
endmodule

bind atapi_xfer_ctrl atapi_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .status_q(status_q), .error_q(error_q), .count_q(count_q),
  .irq_pending(irq_pending), .raise(raise), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_data(pkt_data), .dma_done(dma_done), .next_sector_req(next_sector_req)
);

// File: tb/atapi_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module atapi_xfer_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic reg_wr = 0, reg_rd = 0; logic [2:0] reg_addr = 0; logic [7:0] reg_wdata = 0, reg_rdata;
  logic data_wr = 0, data_rd = 0; logic [15:0] data_wdata = 0, data_rdata;
  logic intrq, pkt_valid, pkt_ready = 0, pkt_after_reset; logic [95:0] pkt_data;
  logic ph_start = 0, ph_dir_in = 0, cmd_done = 0; logic [15:0] ph_len = 0, ph_sectors = 0;
  logic next_sector_req, fill_valid = 0, fill_ready; logic [15:0] fill_data = 0;
  logic [4:0] buf_raddr = 0; logic [15:0] buf_rdata;
  logic dma_rd_valid, dma_rd_ready = 0, dma_wr_valid = 0, dma_wr_ready, dma_done;
  logic [15:0] dma_rd_data, dma_wr_data = 0;

  atapi_xfer_ctrl u_dut (.*);

  int checks = 0, fails = 0, nsr_cnt = 0, dd_cnt = 0;
  bit done = 0;
  logic [15:0] exp_w [32];
  logic [15:0] pw [6];
  logic [15:0] exp_bc;

  always @(posedge clk) begin
    if (next_sector_req) nsr_cnt++;
    if (dma_done) dd_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic rw(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic rr(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1; #1 d = reg_rdata; tick(); reg_rd = 0;
  endtask

  task automatic dw(input logic [15:0] w);
    data_wdata = w; data_wr = 1; tick(); data_wr = 0;
  endtask

  task automatic dr(output logic [15:0] w);
    data_rd = 1; #1 w = data_rdata; tick(); data_rd = 0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) begin
      exp_w[i] = 16'($urandom);
      fill_data = exp_w[i]; fill_valid = 1; #1;
      chk("R3 fill_ready", fill_ready, 1);
      tick();
    end
    fill_valid = 0;
  endtask

  task automatic start(input bit din, input int len, input int secs);
    ph_dir_in = din; ph_len = 16'(len); ph_sectors = 16'(secs); ph_start = 1; tick(); ph_start = 0;
  endtask

  task automatic send_packet(input logic [7:0] feat, input bit exp_rst);
    logic [7:0] v;
    rw(3'd0, feat);
    rw(3'd6, 8'hA0);
    rr(3'd7, v); chk("R2 status", v, 8'h58);
    rr(3'd0, v); chk("R2 error", v, {6'b0, feat[1:0]});
    rr(3'd1, v); chk("R2 count", v, 8'h01);
    for (int i = 0; i < 6; i++) begin pw[i] = 16'($urandom); dw(pw[i]); end
    rr(3'd7, v); chk("R3 status", v, 8'hD0);
    chk("R3 valid", pkt_valid, 1);
    for (int i = 0; i < 6; i++) chk("R3 data", pkt_data[16*i +: 16], pw[i]);
    chk("R3 after_reset", pkt_after_reset, exp_rst);
    tick(); tick();
    chk("R3 hold", pkt_valid, 1);
    pkt_ready = 1; tick(); pkt_ready = 0;
    chk("R3 taken", pkt_valid, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v; logic [15:0] w; int len, n, n0, d0;
    void'($urandom(32'h5EED_0042));
    tick(); tick(); rst_n = 1; tick();

    // Reset state
    rr(3'd0, v); chk("R1 error", v, 8'h01);
    rr(3'd1, v); chk("R1 count", v, 8'h01);
    rr(3'd2, v); chk("R1 sector", v, 8'h81);
    rr(3'd3, v); chk("R1 bc_lo", v, 8'h14);
    rr(3'd4, v); chk("R1 bc_hi", v, 8'hEB);
    rr(3'd7, v); chk("R1 status", v, 8'h00);
    chk("R1 intrq", intrq, 0);
    exp_bc = 16'hEB14;

    send_packet(8'h02, 1);

    // PIO read, two sectors, random length each
    for (int s = 0; s < 2; s++) begin
      len = $urandom_range(1, 32) * 2; n = len / 2;
      fill(n);
      n0 = nsr_cnt;
      start(1, len, 1 - s);
      exp_bc = 16'(len);
      rr(3'd7, v); chk("R4 status", v, 8'h58);
      rr(3'd1, v); chk("R4 count", v, 8'h02);
      rr(3'd0, v); chk("R4 error", v, 8'h00);
      rr(3'd3, v); chk("R4 bc_lo", v, exp_bc[7:0]);
      rr(3'd4, v); chk("R4 bc_hi", v, exp_bc[15:8]);
      chk("R4 intrq", intrq, 1);
      rr(3'd6, v); chk("R9 cleared", intrq, 0);
      for (int i = 0; i < n; i++) begin dr(w); chk("R6 word", w, exp_w[i]); end
      rr(3'd7, v); chk("R6 status", v, 8'h50);
      rr(3'd1, v); chk("R6 count", v, 8'h03);
      chk("R6 intrq", intrq, 1);
      tick();
      chk("R6 next_sector", nsr_cnt - n0, (s == 0) ? 1 : 0);
    end

    // Read outside a read phase
    dr(w); chk("R12 data", w, 16'hFFFF);
    rr(3'd7, v); chk("R12 status", v, 8'h50);
    rr(3'd1, v); chk("R12 count", v, 8'h03);

    // Mask, alternate status
    rw(3'd7, 8'h02); chk("R10 masked", intrq, 0);
    rr(3'd7, v);
    rw(3'd7, 8'h00); chk("R10 kept", intrq, 1);
    chk("R9 alt no clear", intrq, 1);

    // Unknown command
    rw(3'd6, 8'h55); chk("R13 clear", intrq, 0);
    rr(3'd7, v); chk("R13 status", v, 8'h50);

    // DMA read with chained sector
    send_packet(8'h01, 0);
    len = $urandom_range(1, 32) * 2; n = len / 2;
    fill(n); n0 = nsr_cnt;
    start(1, len, 1);
    rr(3'd7, v); chk("R5 status", v, 8'hD0);
    rr(3'd3, v); chk("R5 bc_lo", v, exp_bc[7:0]);
    rr(3'd4, v); chk("R5 bc_hi", v, exp_bc[15:8]);
    chk("R5 intrq", intrq, 0);
    dma_rd_ready = 1;
    for (int i = 0; i < n; i++) begin
      #1 chk("R5 valid", dma_rd_valid, 1); chk("R5 word", dma_rd_data, exp_w[i]); tick();
    end
    dma_rd_ready = 0; tick();
    chk("R8 next_sector", nsr_cnt - n0, 1);
    rr(3'd7, v); chk("R8 status busy", v, 8'hD0);
    len = $urandom_range(1, 32) * 2; n = len / 2;
    fill(n); d0 = dd_cnt;
    start(1, len, 0);
    for (int i = 0; i < n; i++) begin
      dma_rd_ready = ($urandom_range(0, 1) == 1);
      #1 if (dma_rd_ready) chk("R8 word", dma_rd_data, exp_w[i]); else i--;
      tick();
    end
    dma_rd_ready = 0; tick();
    chk("R8 dma_done", dd_cnt - d0, 1);
    rr(3'd7, v); chk("R8 status", v, 8'h50);
    rr(3'd1, v); chk("R8 count", v, 8'h03);
    chk("R8 intrq", intrq, 1);

    // PIO write
    send_packet(8'h00, 0);
    len = $urandom_range(1, 32) * 2; n = len / 2;
    start(0, len, 0);
    rr(3'd1, v); chk("R4 count out", v, 8'h00);
    rr(3'd3, v); chk("R4 bc_lo out", v, 8'(len));
    for (int i = 0; i < n; i++) begin exp_w[i] = 16'($urandom); dw(exp_w[i]); end
    rr(3'd7, v); chk("R7 status", v, 8'h50);
    rr(3'd1, v); chk("R7 count", v, 8'h03);
    chk("R7 intrq", intrq, 1);
    for (int i = 0; i < n; i++) begin buf_raddr = 5'(i); #1 chk("R7 buffer", buf_rdata, exp_w[i]); end

    // DMA write
    send_packet(8'h01, 0);
    len = $urandom_range(1, 32) * 2; n = len / 2; d0 = dd_cnt;
    start(0, len, 0);
    for (int i = 0; i < n; i++) begin
      exp_w[i] = 16'($urandom); dma_wr_data = exp_w[i]; dma_wr_valid = 1;
      #1 chk("R8 wr_ready", dma_wr_ready, 1); tick();
    end
    dma_wr_valid = 0; tick();
    chk("R8 wr dma_done", dd_cnt - d0, 1);
    rr(3'd7, v); chk("R8 wr status", v, 8'h50);
    for (int i = 0; i < n; i++) begin buf_raddr = 5'(i); #1 chk("R8 wr buffer", buf_rdata, exp_w[i]); end

    // Abort in mid read
    send_packet(8'h00, 0);
    fill(4); start(1, 8, 0);
    dr(w); chk("R6 first", w, exp_w[0]);
    rw(3'd6, 8'h00);
    rr(3'd7, v); chk("R11 status", v, 8'h51);
    rr(3'd0, v); chk("R11 error", v, 8'h04);
    chk("R11 intrq", intrq, 1);
    dr(w); chk("R11 data", w, 16'hFFFF);

    // Decoder completes with no data
    send_packet(8'h00, 0);
    cmd_done = 1; tick(); cmd_done = 0;
    rr(3'd7, v); chk("R14 status", v, 8'h50);
    rr(3'd1, v); chk("R14 count", v, 8'h03);
    chk("R14 intrq", intrq, 1);

    // Device reset command
    rw(3'd6, 8'h08);
    rr(3'd0, v); chk("R1 rst error", v, 8'h01);
    rr(3'd2, v); chk("R1 rst sector", v, 8'h81);
    rr(3'd4, v); chk("R1 rst bc_hi", v, 8'hEB);
    rr(3'd7, v); chk("R1 rst status", v, 8'h00);
    chk("R1 rst intrq", intrq, 0);
    send_packet(8'h00, 1);

    finish_up();
  end
endmodule